// File: doc/BRIEF.md
# Card Function Configuration and Pin-Status Registers

This block is the per-function register file of a removable I/O card. The host reaches it over a byte-wide register bus. It holds two byte registers. The first is a configuration/status byte. It reports the function's interrupt request, and it holds the host's 8-bit data-path selection plus a few control bits that are stored but have no effect. The second is a pin-status byte. It mirrors four card status inputs (ready, write-protect and two battery-level detects). Next to each live bit it keeps a sticky flag that records any transition of that bit.

A small access state machine serves the bus and has three states. `ST_IDLE` waits for a request. The transition *accept-write* (request with write set) goes to `ST_WRITE`. The transition *accept-read* (request with write clear) goes to `ST_READ`. Both `ST_WRITE` and `ST_READ` take the *complete* transition back to `ST_IDLE` after one cycle. In doing so they commit the write or register the read data, and they raise a one-cycle acknowledge. The status inputs are asynchronous. Each passes through a two-flop synchronizer before edge detection.

Top module: `pcfg_regfile`

## Requirements
- R1: After reset, `bus_ack` and `byte_path_only` are 0, and with all status inputs low both registers read 0x00.
- R2: A request sampled in `ST_IDLE` on clock edge A yields `bus_ack` high for exactly one cycle after edge A+1. Read data is valid on `bus_rdata` at the same time and is held afterwards.
- R3: The pin-status register is at offset 0xFC. Its low nibble is live: bit 3 battery-detect 1, bit 2 battery-detect 2, bit 1 ready, bit 0 write-protect. Each bit follows its input two clock edges after the input changes.
- R4: Bits 7..4 of the pin-status register are change flags for bits 3..0 in the same order. A flag becomes 1 on a rise or a fall of its live bit and stays 1.
- R5: A write to offset 0xFC loads the change flags from write-data bits 7..4: a 1 sets a flag and a 0 clears it. Write-data bits 3..0 are ignored.
- R6: If a live-bit transition is detected in the same cycle as a host write of 0 to its change flag, the flag ends up 1.
- R7: The configuration/status register is at offset 0x02. Bit 5 is the 8-bit path select. It is read/write and drives `byte_path_only`.
- R8: In the configuration/status register, bit 1 reads the current `irq_req`, bit 0 always reads 0 whatever is written, and bit 4 always reads 0.
- R9: Configuration/status bits 6, 3 and 2 are read/write storage only. Writing them changes no output.
- R10: Configuration/status bit 7 is read-only and reads 1 whenever any of the four change flags is 1.
- R11: Reads of any other offset return 0x00. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low card reset |
| bus_req | input | 1 | Access request, sampled in idle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_ack | output | 1 | One-cycle completion pulse |
| irq_req | input | 1 | Function interrupt request |
| pin_ready | input | 1 | Asynchronous ready status |
| pin_wprot | input | 1 | Asynchronous write-protect status |
| pin_batt1 | input | 1 | Asynchronous battery-detect 1 |
| pin_batt2 | input | 1 | Asynchronous battery-detect 2 |
| byte_path_only | output | 1 | Host asked for 8-bit-only data path |

## Verification
The status inputs are driven through single rises, single falls and simultaneous changes on two pins, with host clears in between. This separates per-bit edge detection from a shared flag, and rise-only from both-edge detection. Write patterns of all ones and all zeros reach both registers and an unmapped offset. These show which bits are stored, which are fixed at zero and which only follow an input. A write that clears a flag is timed so that it lands in the exact cycle a transition is detected, and a matching write without a transition is run as a control. Together the two tell the priority rule apart from plain overwrite.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_t;

    localparam int NPIN = 4;

    // configuration/status bit positions
    localparam int CB_ACK     = 0;
    localparam int CB_IRQ     = 1;
    localparam int CB_PWR     = 2;
    localparam int CB_AUDIO   = 3;
    localparam int CB_RSVD    = 4;
    localparam int CB_PATH8   = 5;
    localparam int CB_SIGEN   = 6;
    localparam int CB_CHANGED = 7;
endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/pcfg_change.sv
module pcfg_change #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic         host_wr,
    input  logic [W-1:0] host_val,
    output logic [W-1:0] flag
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic evt;
        assign evt = live[i] ^ prev_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                flag[i]   <= 1'b0;
            end else begin
                prev_q[i] <= live[i];
                if (evt)
                    flag[i] <= 1'b1;          // detected transition outranks a host clear
                else if (host_wr)
                    flag[i] <= host_val[i];
            end
        end

        // R4 / R6: any detected transition leaves the flag set
        a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (live[i] != prev_q[i]) |=> flag[i]);

        // R5: without a transition, a host write loads the flag
        a_r5_write_loads_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && (live[i] == prev_q[i])) |=> (flag[i] == $past(host_val[i])));
    end
endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
    import pcfg_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CFG_OFS = 8'h02,
    parameter logic [ADDR_W-1:0] PIN_OFS = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_ack,
    input  logic              irq_req,
    input  logic              pin_ready,
    input  logic              pin_wprot,
    input  logic              pin_batt1,
    input  logic              pin_batt2,
    output logic              byte_path_only
);
    bus_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    logic [NPIN-1:0] live;
    logic [NPIN-1:0] chg;
    logic            chg_wr;
    logic            cfg_wr;
    logic            path8_q, sigen_q, audio_q, pwr_q;
    logic [7:0]      rd_mux;

    // live order: [3] batt1, [2] batt2, [1] ready, [0] wprot
    pcfg_sync #(.W(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pin_batt1, pin_batt2, pin_ready, pin_wprot}),
        .sync_out (live)
    );

    assign chg_wr = (state_q == ST_WRITE) && (addr_q == PIN_OFS);
    assign cfg_wr = (state_q == ST_WRITE) && (addr_q == CFG_OFS);

    pcfg_change #(.W(NPIN)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .host_wr  (chg_wr),
        .host_val (data_q[7:4]),
        .flag     (chg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (bus_req) begin
                    state_q <= bus_wr ? ST_WRITE : ST_READ;
                    addr_q  <= bus_addr;
                    data_q  <= bus_wdata;
                end
                ST_WRITE: state_q <= ST_IDLE;
                ST_READ:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path8_q <= 1'b0;
            sigen_q <= 1'b0;
            audio_q <= 1'b0;
            pwr_q   <= 1'b0;
        end else if (cfg_wr) begin
            path8_q <= data_q[CB_PATH8];
            sigen_q <= data_q[CB_SIGEN];
            audio_q <= data_q[CB_AUDIO];
            pwr_q   <= data_q[CB_PWR];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr_q == CFG_OFS) begin
            rd_mux[CB_CHANGED] = |chg;
            rd_mux[CB_SIGEN]   = sigen_q;
            rd_mux[CB_PATH8]   = path8_q;
            rd_mux[CB_AUDIO]   = audio_q;
            rd_mux[CB_PWR]     = pwr_q;
            rd_mux[CB_IRQ]     = irq_req;
        end else if (addr_q == PIN_OFS) begin
            rd_mux = {chg, live};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  bus_ack <= 1'b0;
                ST_WRITE: bus_ack <= 1'b1;
                ST_READ: begin
                    bus_ack   <= 1'b1;
                    bus_rdata <= rd_mux;
                end
                default:  bus_ack <= 1'b0;
            endcase
        end
    end

    assign byte_path_only = path8_q;

    // R2: acknowledge is a single-cycle pulse
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R8: acknowledge and reserved bits of the config byte read zero
    a_r8_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && addr_q == CFG_OFS) |=>
            (bus_rdata[CB_ACK] == 1'b0 && bus_rdata[CB_RSVD] == 1'b0));

    // R7: path select moves only after a config write
    a_r7_path_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_path_only) |-> $past(cfg_wr));

    // R10: summary bit matches the change flags at the read
    a_r10_changed_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && addr_q == CFG_OFS) |=>
            (bus_rdata[CB_CHANGED] == $past(|chg)));

    // R11: unmapped reads return zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && addr_q != CFG_OFS && addr_q != PIN_OFS) |=>
            (bus_rdata == 8'h00));
endmodule

// File: tb/sim_pcfg_regfile.sv
`timescale 1ns/1ps
module sim_pcfg_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic       irq_req = 1'b0;
    logic       pin_ready = 1'b0, pin_wprot = 1'b0, pin_batt1 = 1'b0, pin_batt2 = 1'b0;
    logic       byte_path_only;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcfg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq_req(irq_req), .pin_ready(pin_ready),
        .pin_wprot(pin_wprot), .pin_batt1(pin_batt1), .pin_batt2(pin_batt2),
        .byte_path_only(byte_path_only)
    );

    // {wr, addr, wdata, pins(batt1,batt2,ready,wprot), irq, expected read}
    localparam int NV = 18;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 8'hFC, 8'h00, 4'b0000, 1'b0, 8'h00},  // R3 idle
        {1'b0, 8'hFC, 8'h00, 4'b0010, 1'b0, 8'h22},  // R3 R4 ready rises
        {1'b0, 8'h02, 8'h00, 4'b0010, 1'b1, 8'h82},  // R8 R10
        {1'b1, 8'hFC, 8'h00, 4'b0010, 1'b0, 8'h00},  // R5 clear
        {1'b0, 8'hFC, 8'h00, 4'b0010, 1'b0, 8'h02},  // R5
        {1'b0, 8'hFC, 8'h00, 4'b1011, 1'b0, 8'h9B},  // R4 two pins rise
        {1'b1, 8'hFC, 8'h00, 4'b1011, 1'b0, 8'h00},  // R5 clear
        {1'b0, 8'hFC, 8'h00, 4'b1001, 1'b0, 8'h29},  // R4 fall sets flag
        {1'b1, 8'h02, 8'hFF, 4'b1001, 1'b0, 8'h00},  // R7 R8 R9 write ones
        {1'b0, 8'h02, 8'h00, 4'b1001, 1'b0, 8'hEC},  // R8 R9 R10
        {1'b1, 8'hFC, 8'h4F, 4'b1001, 1'b0, 8'h00},  // R5 set / ignore live
        {1'b0, 8'hFC, 8'h00, 4'b1001, 1'b0, 8'h49},  // R5
        {1'b1, 8'h02, 8'h00, 4'b1001, 1'b0, 8'h00},  // R7 write zeros
        {1'b0, 8'h02, 8'h00, 4'b1001, 1'b1, 8'h82},  // R8 R10
        {1'b0, 8'h40, 8'h00, 4'b1001, 1'b0, 8'h00},  // R11 read
        {1'b1, 8'h40, 8'hFF, 4'b1001, 1'b0, 8'h00},  // R11 write
        {1'b0, 8'hFC, 8'h00, 4'b1001, 1'b0, 8'h49},  // R11 no effect
        {1'b0, 8'h02, 8'h00, 4'b1001, 1'b0, 8'h80}   // R11 no effect
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {pin_batt1, pin_batt2, pin_ready, pin_wprot} = p;
    endtask

    // request before edge A, ack after edge A+1 (R2)
    task automatic access(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        check("R2 ack low after accept", {7'd0, bus_ack}, 8'h00);
        @(negedge clk);
        check("R2 ack high", {7'd0, bus_ack}, 8'h01);
        rd = bus_rdata;
        @(negedge clk);
        check("R2 ack one cycle", {7'd0, bus_ack}, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", {7'd0, bus_ack}, 8'h00);
        check("R1 path", {7'd0, byte_path_only}, 8'h00);
        access(1'b0, 8'hFC, 8'h00, rd); check("R1 pin reg", rd, 8'h00);
        access(1'b0, 8'h02, 8'h00, rd); check("R1 cfg reg", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_pins(VEC[i][12:9]);
            irq_req = VEC[i][8];
            repeat (4) @(negedge clk);
            access(VEC[i][29], VEC[i][28:21], VEC[i][20:13], rd);
            if (!VEC[i][29]) check($sformatf("R3-11 vector %0d", i), rd, VEC[i][7:0]);
            if (i == 8)  check("R7 path set", {7'd0, byte_path_only}, 8'h01);
            if (i == 12) check("R7 path clear", {7'd0, byte_path_only}, 8'h00);
        end

        // R9: storage-only bits leave the path output alone
        access(1'b1, 8'h02, 8'h4C, rd);
        check("R9 no output effect", {7'd0, byte_path_only}, 8'h00);
        access(1'b1, 8'h02, 8'h01, rd);
        access(1'b0, 8'h02, 8'h00, rd);
        check("R8 ack bit ignores write", rd, 8'h80);

        // R6: clear lands in the cycle the wprot fall is detected
        @(negedge clk);
        pin_wprot = 1'b0;                 // edge X next
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 8'hFC; bus_wdata = 8'h00;
        @(negedge clk);                   // edge X+1 accepts
        bus_req = 1'b0;
        @(negedge clk);                   // edge X+2 writes, event detected
        repeat (3) @(negedge clk);
        access(1'b0, 8'hFC, 8'h00, rd);
        check("R6 event beats clear", rd, 8'h18);
        // control: same clear without a transition
        access(1'b1, 8'hFC, 8'h00, rd);
        access(1'b0, 8'hFC, 8'h00, rd);
        check("R5 clear without event", rd, 8'h08);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule